// File: doc/BRIEF.md
# Read-Triggered ADC Conversion Controller

This block is the digital front end of a multi-channel successive-approximation converter that has analog multiplexing switches. Software drives it over a small register bus (address, write enable, read enable, write data, read data). The act of reading the result register is the conversion trigger. That same read returns whatever the previous conversion produced, and the held result is then discarded. A later read of the result register returns the new sample with a data-ready flag in bit 31, once the conversion timer has expired.

The analog switch setting sits behind a one-shot key. A switch write is accepted only if the bus write just before it was the key value to the lock register. An accepted switch change starts a settling interval, and no conversion may complete during it. The settling and conversion intervals are counted in ticks of a divided module clock. The divisor is either 4 or 16, chosen by an input pin. The converter core is not modelled: a sample input port stands in for it and is captured on the cycle the conversion timer expires.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset the switch output and its readback are 0, the lock is engaged, and a read of the result register returns 0 (data-ready flag low).
- R2: A read of address 0x08 starts a conversion. Exactly DIV*CONV_TICKS clock cycles after the triggering edge, the value on `smp_in` is captured and the data-ready flag (bit 31) rises. The next read of 0x08 returns the flag and the sample, then clears them.
- R3: A read of 0x08 made while a conversion is running returns bit 31 as 0 and data 0, and restarts the full conversion interval from that read.
- R4: The result word carries the sample in bits 15:0 as two's complement, copies of bit 15 in bits 30:16, and the data-ready flag in bit 31. The bench drives samples from -25000 to +25000.
- R5: Writing exactly 0x000000AA to address 0x20 arms the key. The very next bus write, if it targets address 0x18, loads bits 11:0 into the switch register. That register drives `sw_cfg` and reads back at 0x18 in bits 11:0. The channel settings used are 0x608, 0x680, 0x640, 0x620, 0x610, 0x601, 0x602 and 0x604, for channels 0 to 7.
- R6: A write to 0x18 without an armed key is ignored. Any bus write other than the armed switch write disarms the key, and this includes a write of any other value to 0x20. An armed key serves a single write. Reads do not disarm it.
- R7: An accepted switch write drops the data-ready flag and starts a settling interval of DIV*SETTLE_TICKS cycles. A conversion that was running at the switch write, or that is requested during settling, starts when settling ends. Ready therefore rises exactly DIV*(SETTLE_TICKS+CONV_TICKS) cycles after the switch write.
- R8: `div_sel`=0 selects divisor 4 and `div_sel`=1 selects divisor 16. All interval lengths scale with the selected divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, taken from registered state |
| div_sel | input | 1 | Module clock divisor select: 0 for 4, 1 for 16 |
| smp_in | input | 16 | Converter sample, captured when the conversion timer expires |
| sw_cfg | output | 12 | Analog switch setting |

## Verification
The hardest case to reach is a conversion request that overlaps a switch change. The request must be held through the whole settling interval and then serviced without another read, because any extra read would itself restart the timer. The bench first triggers a conversion and then, while it is still running, arms the key and writes a new switch setting. It then waits exactly the combined settling and conversion time before its single observing read, and it repeats the exact-boundary reads one cycle early and on time for both divisors. Random bus-write sequences against a bench model of the one-shot key cover arming, disarming and ignored switch writes.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] ADDR_RESULT = 8'h08;
    localparam logic [BUS_AW-1:0] ADDR_SWITCH = 8'h18;
    localparam logic [BUS_AW-1:0] ADDR_LOCK   = 8'h20;
    localparam logic [BUS_DW-1:0] KEY_VALUE   = 32'h0000_00AA;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_CONV   = 2'd2
    } phase_e;
endpackage

// File: rtl/adc_prescaler.sv
// Module clock divider: emits one tick every DIV cycles, phase restartable.
module adc_prescaler #(
    parameter int DIV_FAST = 4,
    parameter int DIV_SLOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic slow,
    output logic tick
);
    localparam int PRE_W = $clog2(DIV_SLOW);

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        last  = slow ? PRE_W'(DIV_SLOW - 1) : PRE_W'(DIV_FAST - 1);
        tick  = (cnt_q >= last);
        cnt_d = cnt_q + PRE_W'(1);
        if (restart || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_key_lock.sv
// One-shot software key guarding the switch register.
module adc_key_lock
    import adc_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic              sw_wr,
    output logic              unlocked
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        sw_wr   = bus_we && (bus_addr == ADDR_SWITCH) && armed_q;
        if (bus_we) begin
            armed_d = (bus_addr == ADDR_LOCK) && (bus_wdata == KEY_VALUE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    assign unlocked = armed_q;
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import adc_trig_pkg::*;
#(
    parameter int SMP_W        = 16,
    parameter int SW_W         = 12,
    parameter int DIV_FAST     = 4,
    parameter int DIV_SLOW     = 16,
    parameter int CONV_TICKS   = 4,
    parameter int SETTLE_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              div_sel,
    input  logic [SMP_W-1:0]  smp_in,
    output logic [SW_W-1:0]   sw_cfg
);
    localparam int MAX_TICKS = (CONV_TICKS > SETTLE_TICKS) ? CONV_TICKS : SETTLE_TICKS;
    localparam int TCNT_W    = $clog2(MAX_TICKS + 1);
    localparam int EXT_W     = BUS_DW - 1 - SMP_W;

    typedef struct packed {
        phase_e             phase;
        logic               pend;
        logic               ready;
        logic [SMP_W-1:0]   sample;
        logic [SW_W-1:0]    sw;
        logic [TCNT_W-1:0]  tcnt;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              tick;
    logic              restart;
    logic              sw_wr;
    logic              unlocked;
    logic              trig;
    logic              iv_end;
    logic [TCNT_W-1:0] iv_last;

    // observation points for the bound checker
    logic ready_w, conv_w, unlocked_w;

    adc_prescaler #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .slow    (div_sel),
        .tick    (tick)
    );

    adc_key_lock u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .sw_wr     (sw_wr),
        .unlocked  (unlocked)
    );

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        trig    = bus_re && (bus_addr == ADDR_RESULT);
        iv_last = (st_q.phase == PH_SETTLE) ? TCNT_W'(SETTLE_TICKS - 1)
                                            : TCNT_W'(CONV_TICKS - 1);
        iv_end  = tick && (st_q.phase != PH_IDLE) && (st_q.tcnt == iv_last);

        if (tick && (st_q.phase != PH_IDLE)) begin
            st_d.tcnt = st_q.tcnt + TCNT_W'(1);
        end

        // interval expiry
        if (iv_end) begin
            st_d.tcnt = '0;
            if (st_q.phase == PH_SETTLE) begin
                if (st_q.pend) begin
                    st_d.phase = PH_CONV;
                    st_d.pend  = 1'b0;
                    restart    = 1'b1;
                end else begin
                    st_d.phase = PH_IDLE;
                end
            end else begin
                st_d.phase  = PH_IDLE;
                st_d.ready  = 1'b1;
                st_d.sample = smp_in;
            end
        end

        // result read: discard held value and (re)start a conversion
        if (trig) begin
            st_d.ready  = 1'b0;
            st_d.sample = '0;
            if (st_d.phase == PH_SETTLE) begin
                st_d.pend = 1'b1;
            end else begin
                st_d.phase = PH_CONV;
                st_d.tcnt  = '0;
                restart    = 1'b1;
            end
        end

        // accepted switch change: settle first, keep any conversion request
        if (sw_wr) begin
            st_d.sw     = bus_wdata[SW_W-1:0];
            st_d.pend   = st_d.pend || (st_d.phase == PH_CONV);
            st_d.phase  = PH_SETTLE;
            st_d.tcnt   = '0;
            st_d.ready  = 1'b0;
            st_d.sample = '0;
            restart     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.pend   <= 1'b0;
            st_q.ready  <= 1'b0;
            st_q.sample <= '0;
            st_q.sw     <= '0;
            st_q.tcnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_RESULT: bus_rdata = {st_q.ready, {EXT_W{st_q.sample[SMP_W-1]}}, st_q.sample};
            ADDR_SWITCH: bus_rdata = {{(BUS_DW-SW_W){1'b0}}, st_q.sw};
            default:     bus_rdata = '0;
        endcase
    end

    assign sw_cfg     = st_q.sw;
    assign ready_w    = st_q.ready;
    assign conv_w     = (st_q.phase == PH_CONV);
    assign unlocked_w = unlocked;
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk
    import adc_trig_pkg::*;
#(
    parameter int SW_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [BUS_DW-1:0] bus_rdata,
    input logic [SW_W-1:0]   sw_cfg,
    input logic              ready,
    input logic              conv,
    input logic              unlocked
);
    // R3: a triggering read always clears the flag for the next cycle
    a_r3_trigger_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADDR_RESULT) |=> !ready);

    // R2: the flag only rises when a conversion was running
    a_r2_ready_from_conv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(conv));

    // R4: result word shows flag in bit 31 and sign copies in 30:16
    a_r4_result_format: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_RESULT) |->
            (bus_rdata[31] == ready) && (bus_rdata[30:16] == {15{bus_rdata[15]}}));

    // R5: switch output only changes after an armed key
    a_r5_change_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sw_cfg) |-> $past(unlocked));

    // R6: switch write without key leaves the switch untouched
    a_r6_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_SWITCH && !unlocked) |=> $stable(sw_cfg));

    // R6: any write other than the key write disarms the lock
    a_r6_key_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !(bus_addr == ADDR_LOCK && bus_wdata == KEY_VALUE)) |=> !unlocked);

    // R7: accepted switch write enters settling with the flag low
    a_r7_switch_settles: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_SWITCH && unlocked) |=> (!ready && !conv));
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk #(.SW_W(SW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sw_cfg    (sw_cfg),
    .ready     (ready_w),
    .conv      (conv_w),
    .unlocked  (unlocked_w)
);

// File: tb/adc_trig_ctrl_tb.sv
`timescale 1ns/1ps
module adc_trig_ctrl_tb;
    localparam int CONV_T   = 4;
    localparam int SETTLE_T = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        div_sel = 1'b0;
    logic [15:0] smp_in = '0;
    logic [11:0] sw_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_trig_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .div_sel   (div_sel),
        .smp_in    (smp_in),
        .sw_cfg    (sw_cfg)
    );

    function automatic logic [11:0] enc(input int ch);
        case (ch)
            0: enc = 12'h608;
            1: enc = 12'h680;
            2: enc = 12'h640;
            3: enc = 12'h620;
            4: enc = 12'h610;
            5: enc = 12'h601;
            6: enc = 12'h602;
            default: enc = 12'h604;
        endcase
    endfunction

    function automatic logic [31:0] res_word(input logic rdy, input logic [15:0] s);
        res_word = {rdy, {15{s[15]}}, s};
    endfunction

    function automatic int divisor(input logic sel);
        divisor = sel ? 16 : 4;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_re   = 1'b1;
        #1;
        d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [11:0] exp_sw;
        logic        exp_arm;
        void'($urandom(32'd4242));

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        chk(sw_cfg == 12'h0, "R1 sw_cfg", {20'h0, sw_cfg}, 32'h0);
        bus_read(8'h18, rd);
        chk(rd == 32'h0, "R1 switch readback", rd, 32'h0);
        bus_read(8'h08, rd);
        chk(rd == 32'h0, "R1 result", rd, 32'h0);
        bus_write(8'h18, 32'h608);
        bus_read(8'h18, rd);
        chk(rd == 32'h0, "R1 lock engaged", rd, 32'h0);

        // R5 R6 random key sequences against a model
        exp_sw  = 12'h0;
        exp_arm = 1'b0;
        for (int i = 0; i < 60; i++) begin
            int op;
            logic [7:0]  a;
            logic [31:0] d;
            op = $urandom_range(5);
            case (op)
                0, 1: begin a = 8'h20; d = 32'hAA; end
                2:    begin a = 8'h20; d = 32'h100 | 32'($urandom_range(255)); end
                3, 4: begin a = 8'h18; d = {20'h0, enc($urandom_range(7))}; end
                default: begin a = 8'h10; d = $urandom; end
            endcase
            if (op == 1 && exp_arm) begin
                // a read between key and switch write must not disarm
                bus_read(8'h18, rd);
            end
            bus_write(a, d);
            if (a == 8'h18 && exp_arm) exp_sw = d[11:0];
            exp_arm = (a == 8'h20) && (d == 32'hAA);
            bus_read(8'h18, rd);
            chk(rd == {20'h0, exp_sw} && sw_cfg == exp_sw, "R5/R6 key model",
                rd, {20'h0, exp_sw});
        end

        // R6 directed: key consumed by one write
        bus_write(8'h20, 32'hAA);
        bus_write(8'h18, {20'h0, enc(3)});
        bus_write(8'h18, {20'h0, enc(4)});
        bus_read(8'h18, rd);
        chk(rd == {20'h0, enc(3)}, "R6 one-shot key", rd, {20'h0, enc(3)});
        bus_write(8'h20, 32'hAA);
        bus_write(8'h10, 32'h0);
        bus_write(8'h18, {20'h0, enc(5)});
        chk(sw_cfg == enc(3), "R6 other write disarms", {20'h0, sw_cfg}, {20'h0, enc(3)});
        bus_write(8'h20, 32'h1AA);
        bus_write(8'h18, {20'h0, enc(6)});
        chk(sw_cfg == enc(3), "R6 wrong key value", {20'h0, sw_cfg}, {20'h0, enc(3)});

        wait_cyc(400);

        // R2 R3 R4 R8 random conversions at exact boundaries
        for (int i = 0; i < 14; i++) begin
            logic [15:0] s;
            int c;
            div_sel = (i < 2) ? i[0] : 1'($urandom_range(1));
            c = divisor(div_sel) * CONV_T;
            s = 16'($signed($urandom_range(50000)) - 25000);
            if (i == 2) s = 16'(-25000);
            if (i == 3) s = 16'd25000;
            smp_in = s;
            bus_read(8'h08, rd);
            wait_cyc(c - 1);
            bus_read(8'h08, rd);
            chk(rd == 32'h0, "R3 early read not ready", rd, 32'h0);
            wait_cyc(c);
            bus_read(8'h08, rd);
            chk(rd == res_word(1'b1, s), "R2/R4/R8 sample on time", rd, res_word(1'b1, s));
        end

        // R7 settling boundaries for both divisors
        for (int k = 0; k < 2; k++) begin
            int c, st;
            logic [15:0] s;
            div_sel = k[0];
            c  = divisor(div_sel) * CONV_T;
            st = divisor(div_sel) * SETTLE_T;
            s  = 16'($urandom_range(20000));

            wait_cyc(400);
            smp_in = s;
            bus_write(8'h20, 32'hAA);
            bus_write(8'h18, {20'h0, enc(k)});
            bus_read(8'h08, rd);
            wait_cyc(st + c - 2);
            bus_read(8'h08, rd);
            chk(rd == 32'h0, "R7 one cycle before settle+conv", rd, 32'h0);

            wait_cyc(400);
            bus_write(8'h20, 32'hAA);
            bus_write(8'h18, {20'h0, enc(k + 2)});
            bus_read(8'h08, rd);
            wait_cyc(st + c - 1);
            bus_read(8'h08, rd);
            chk(rd == res_word(1'b1, s), "R7 ready at settle+conv", rd, res_word(1'b1, s));

            // conversion running when the switch changes: held, then serviced
            wait_cyc(400);
            smp_in = ~s;
            bus_read(8'h08, rd);
            bus_write(8'h20, 32'hAA);
            bus_write(8'h18, {20'h0, enc(k + 4)});
            wait_cyc(st + c);
            bus_read(8'h08, rd);
            chk(rd == res_word(1'b1, ~s), "R7 pending conversion kept", rd,
                res_word(1'b1, ~s));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule